// File: doc/BRIEF.md
# Double-Buffered Reference Divider

This block turns a reference clock into the comparison-rate pulse that a phase/frequency detector consumes for one synthesizer channel. The divide ratio is held twice. The control port writes a first stage. That value moves into a second stage only when the loop-divider register write strobe fires. The counter then adopts the second-stage value only after it finishes the count cycle already in progress. In this way the reference ratio and the loop ratio take effect together, and no shortened comparison period occurs.

The 13-bit ratio accepts 1, or any value from 10 to 8191. A write of 0 or of 2 to 9 is refused and raises an error flag. A bypass control forces a pulse on every reference cycle. A second, independent divider drives a reference-output clock at the input rate divided by 1, 2, 4, 8 or 16. A change to its setting is applied on a rising edge of that output, so the output carries no runt pulse.

Top module: `refdiv_dbuf`

## Requirements
- R1: A write on `ratio_wr` carrying a value of 1, or of 10 to 8191, loads the first stage and clears `ratio_err` on the next cycle. The ratio in use is always one of these legal values.
- R2: With ratio N ≥ 10 in use, `ref_pulse` is high for exactly one cycle in every N cycles.
- R3: A write of 0 or of 2 to 9 sets `ratio_err` on the next cycle and leaves the first stage unchanged. A later transfer therefore moves the previously accepted value.
- R4: With ratio 1 in use, `ref_pulse` is high on every cycle.
- R5: A value held in the first stage has no effect on `ref_pulse` until `loop_wr` is pulsed.
- R6: After `loop_wr`, the count cycle already in progress completes at the old ratio. The next cycle uses the transferred ratio.
- R7: While `bypass` is high, `ref_pulse` is high on every cycle. The counter keeps running, so it is unaffected when `bypass` drops.
- R8: `refout_sel` code k from 1 to 4 gives `ref_out` a period of 2^k cycles, high for the first half. Codes 5 to 7 act as 4. Code 0 passes `clk` straight through.
- R9: A new `refout_sel` value is adopted only on a rising edge of `ref_out`. When the code in use is 0, every clock edge counts as such an edge.
- R10: After reset, all ratio stages hold 10, the first pulse comes 10 cycles after reset is released, `ratio_err` is 0, and divide-by-1 is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_wr | input | 1 | One-cycle strobe that writes the first stage |
| ratio_in | input | 13 | Ratio value for the first stage |
| loop_wr | input | 1 | Loop-divider write strobe; moves the first stage to the second |
| bypass | input | 1 | Forces a pulse on every cycle |
| refout_sel | input | 3 | Reference-output divide code |
| ref_pulse | output | 1 | Comparison pulse to the phase detector |
| ref_out | output | 1 | Divided reference-output clock |
| ratio_err | output | 1 | Last ratio write was refused |

## Verification
The assertions assume that every input changes synchronously to `clk`, and that `ratio_wr` and `loop_wr` are single-cycle strobes. Given these, the ratio in use can never leave the legal set, and the counter can never exceed that ratio. The stimulus drives all inputs on the falling edge and holds each strobe for one cycle. It feeds forbidden ratios on purpose only through `ratio_in`, which is what the block is meant to screen. It places `loop_wr` and `refout_sel` changes in mid-cycle, so that the deferral rules are exercised away from their trigger edges.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

  // Legal ratio: exactly 1, or at least min_multi.
  function automatic logic ratio_ok(input int unsigned r, input int unsigned min_multi);
    return (r == 1) || (r >= min_multi);
  endfunction

  // Terminal half-period count for a reference-output code.
  function automatic int unsigned half_limit(input int unsigned sel, input int unsigned stages);
    int unsigned e;
    e = (sel > stages) ? stages : sel;
    return (e == 0) ? 0 : ((32'd1 << (e - 1)) - 1);
  endfunction

endpackage

// File: rtl/ratio_buffers.sv
module ratio_buffers #(
  parameter int unsigned RATIO_W     = 13,
  parameter int unsigned MIN_MULTI   = 10,
  parameter int unsigned RESET_RATIO = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [RATIO_W-1:0] wr_data,
  input  logic               xfer,
  input  logic               reload,
  output logic [RATIO_W-1:0] nxt_ratio,
  output logic               pend,
  output logic               err
);
  import refdiv_pkg::*;

  logic [RATIO_W-1:0] staged;
  logic               wr_ok;

  assign wr_ok = ratio_ok(32'(wr_data), MIN_MULTI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      staged    <= RATIO_W'(RESET_RATIO);
      nxt_ratio <= RATIO_W'(RESET_RATIO);
      pend      <= 1'b0;
      err       <= 1'b0;
    end else begin
      if (wr_en && wr_ok) staged <= wr_data;
      if (wr_en) err <= !wr_ok;
      if (xfer) nxt_ratio <= staged;
      if (xfer) pend <= 1'b1;
      else if (reload) pend <= 1'b0;
    end
  end

  // R3: a refused write leaves the first stage untouched
  assert_staged_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_ok) |=> $stable(staged));

  // R3: a refused write raises the flag
  assert_err_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_ok) |=> err);

  // R5: second stage moves only on a transfer strobe
  assert_nxt_only_on_xfer_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> $stable(nxt_ratio));

endmodule

// File: rtl/ref_counter.sv
module ref_counter #(
  parameter int unsigned RATIO_W     = 13,
  parameter int unsigned MIN_MULTI   = 10,
  parameter int unsigned RESET_RATIO = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] nxt_ratio,
  input  logic               pend,
  output logic               reload,
  output logic               pulse
);
  import refdiv_pkg::*;

  logic [RATIO_W-1:0] cur;
  logic [RATIO_W-1:0] cnt;
  logic [RATIO_W-1:0] next_cur;

  assign reload   = (cnt == RATIO_W'(1));
  assign pulse    = reload;
  assign next_cur = pend ? nxt_ratio : cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= RATIO_W'(RESET_RATIO);
      cnt <= RATIO_W'(RESET_RATIO);
    end else if (reload) begin
      cur <= next_cur;
      cnt <= next_cur;
    end else begin
      cnt <= cnt - RATIO_W'(1);
    end
  end

  // R1: the ratio in use is always legal
  assert_ratio_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_ok(32'(cur), MIN_MULTI));

  // R2: the count stays between 1 and the ratio in use
  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) && (cnt <= cur));

  // R6: the ratio in use changes only at the end of a count cycle
  assert_cur_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cur != $past(cur)) |-> $past(reload));

endmodule

// File: rtl/refout_divider.sv
module refout_divider #(
  parameter int unsigned STAGES = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [$clog2(STAGES+1)-1:0]      sel_in,
  output logic                             ref_out
);
  import refdiv_pkg::*;

  localparam int unsigned SEL_W = $clog2(STAGES + 1);
  localparam int unsigned HW    = (STAGES > 1) ? STAGES - 1 : 1;

  logic [SEL_W-1:0] cur_sel;
  logic [HW-1:0]    hcnt;
  logic [HW-1:0]    lim;
  logic             q;

  assign lim     = HW'(half_limit(32'(cur_sel), STAGES));
  assign ref_out = (cur_sel == '0) ? clk : q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_sel <= '0;
      hcnt    <= '0;
      q       <= 1'b0;
    end else if (cur_sel == '0) begin
      cur_sel <= sel_in;
      hcnt    <= '0;
      q       <= 1'b1;
    end else if (hcnt == lim) begin
      hcnt <= '0;
      q    <= !q;
      if (!q) cur_sel <= sel_in;
    end else begin
      hcnt <= hcnt + HW'(1);
    end
  end

  // R9: the code in use changes only on an output rising edge
  assert_sel_on_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_sel != $past(cur_sel)) |-> (($past(cur_sel) == '0) || (q && !$past(q))));

  // R8: half-period counter never passes its limit
  assert_half_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hcnt <= lim);

endmodule

// File: rtl/refdiv_dbuf.sv
module refdiv_dbuf #(
  parameter int unsigned RATIO_W       = 13,
  parameter int unsigned MIN_MULTI     = 10,
  parameter int unsigned RESET_RATIO   = 10,
  parameter int unsigned REFOUT_STAGES = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                ratio_wr,
  input  logic [RATIO_W-1:0]                  ratio_in,
  input  logic                                loop_wr,
  input  logic                                bypass,
  input  logic [$clog2(REFOUT_STAGES+1)-1:0]  refout_sel,
  output logic                                ref_pulse,
  output logic                                ref_out,
  output logic                                ratio_err
);

  logic [RATIO_W-1:0] nxt_ratio;
  logic               pend;
  logic               reload;
  logic               cnt_pulse;

  ratio_buffers #(
    .RATIO_W(RATIO_W), .MIN_MULTI(MIN_MULTI), .RESET_RATIO(RESET_RATIO)
  ) u_bufs (
    .clk(clk), .rst_n(rst_n), .wr_en(ratio_wr), .wr_data(ratio_in),
    .xfer(loop_wr), .reload(reload), .nxt_ratio(nxt_ratio),
    .pend(pend), .err(ratio_err)
  );

  ref_counter #(
    .RATIO_W(RATIO_W), .MIN_MULTI(MIN_MULTI), .RESET_RATIO(RESET_RATIO)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n), .nxt_ratio(nxt_ratio), .pend(pend),
    .reload(reload), .pulse(cnt_pulse)
  );

  refout_divider #(.STAGES(REFOUT_STAGES)) u_rout (
    .clk(clk), .rst_n(rst_n), .sel_in(refout_sel), .ref_out(ref_out)
  );

  assign ref_pulse = bypass | cnt_pulse;

  // R7: bypass forces a pulse
  assert_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |-> ref_pulse);

endmodule

// File: tb/refdiv_dbuf_tb.sv
module refdiv_dbuf_tb;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ratio_wr = 1'b0;
  logic [12:0] ratio_in = '0;
  logic        loop_wr = 1'b0;
  logic        bypass = 1'b0;
  logic [2:0]  refout_sel = '0;
  logic        ref_pulse, ref_out, ratio_err;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  string req = "R10";

  refdiv_dbuf u_dut (
    .clk(clk), .rst_n(rst_n), .ratio_wr(ratio_wr), .ratio_in(ratio_in),
    .loop_wr(loop_wr), .bypass(bypass), .refout_sel(refout_sel),
    .ref_pulse(ref_pulse), .ref_out(ref_out), .ratio_err(ratio_err)
  );

  always #(PERIOD/2) clk = ~clk;

  // behavioural reference model
  int m_staged, m_nxt, m_cur, m_cnt, m_sel, m_hc;
  bit m_pend, m_err, m_q;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_staged = 10; m_nxt = 10; m_cur = 10; m_cnt = 10;
      m_pend = 0; m_err = 0; m_sel = 0; m_hc = 0; m_q = 0;
    end else begin
      bit ok, rl;
      int n_staged, n_nxt, n_cur, n_cnt, lim, e;
      bit n_pend;
      ok = (ratio_in == 1) || (ratio_in >= 10);
      rl = (m_cnt == 1);
      n_staged = (ratio_wr && ok) ? int'(ratio_in) : m_staged;
      n_nxt    = loop_wr ? m_staged : m_nxt;
      n_pend   = loop_wr ? 1'b1 : (rl ? 1'b0 : m_pend);
      n_cur    = m_cur;
      if (rl) begin
        n_cur = m_pend ? m_nxt : m_cur;
        n_cnt = n_cur;
      end else n_cnt = m_cnt - 1;
      if (ratio_wr) m_err = !ok;
      m_staged = n_staged; m_nxt = n_nxt; m_pend = n_pend;
      m_cur = n_cur; m_cnt = n_cnt;
      if (m_sel == 0) begin
        m_sel = int'(refout_sel); m_hc = 0; m_q = 1;
      end else begin
        e = (m_sel > 4) ? 4 : m_sel;
        lim = (1 << (e - 1)) - 1;
        if (m_hc == lim) begin
          m_hc = 0;
          if (!m_q) m_sel = int'(refout_sel);
          m_q = !m_q;
        end else m_hc = m_hc + 1;
      end
    end
  end

  task automatic cmp(string name, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at %0t: actual=%0b expected=%0b", req, name, $time, act, exp);
    end
  endtask

  // compare every clock, a quarter period after the rising edge
  always @(posedge clk) begin
    #(PERIOD/4);
    if (!done) begin
      cmp("ref_pulse", ref_pulse, bypass || (m_cnt == 1));
      cmp("ref_out", ref_out, (m_sel == 0) ? 1'b1 : m_q);
      cmp("ratio_err", ratio_err, m_err);
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_ratio(int v);
    @(negedge clk); ratio_wr = 1'b1; ratio_in = 13'(v);
    @(negedge clk); ratio_wr = 1'b0;
  endtask

  task automatic pulse_loop();
    @(negedge clk); loop_wr = 1'b1;
    @(negedge clk); loop_wr = 1'b0;
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    req = "R10"; idle(25);                    // reset ratio 10, first pulse after 10 cycles
    req = "R2";  write_ratio(12); pulse_loop(); idle(50);
    req = "R3";  write_ratio(5); idle(3);     // refused: staged stays 12
    pulse_loop(); idle(30);
    write_ratio(0); idle(3);                  // R3: zero is refused too
    req = "R1";  write_ratio(10); idle(2);    // flag cleared by a legal write
    req = "R4";  write_ratio(1); pulse_loop(); idle(20);
    req = "R5";  write_ratio(20); idle(30);   // no transfer: still every cycle
    req = "R6";  pulse_loop(); idle(7);
    write_ratio(11); pulse_loop(); idle(60);  // mid-cycle transfer
    req = "R7";  @(negedge clk); bypass = 1'b1; idle(8);
    @(negedge clk); bypass = 1'b0; idle(25);
    req = "R8";
    for (int s = 1; s < 8; s++) begin
      @(negedge clk); refout_sel = 3'(s); idle(40);
    end
    req = "R9";  @(negedge clk); refout_sel = 3'd1; idle(5);
    @(negedge clk); refout_sel = 3'd3; idle(3);
    @(negedge clk); refout_sel = 3'd0; idle(20);
    @(negedge clk); refout_sel = 3'd2; idle(20);
    req = "R1";  write_ratio(8191); pulse_loop(); idle(8200);
    write_ratio(9); idle(2);                  // R3: upper forbidden edge
    write_ratio(10); pulse_loop(); idle(30);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule